// File: doc/BRIEF.md
# Linked-Descriptor Transmit Queue Engine

This block is a single transmit queue that walks a chain of descriptors held in memory. Software loads the address of the first descriptor into a head-pointer register and then pulses a kick input. The engine reads each descriptor through a word-wide memory read port. It hands the descriptor's buffer address to the transmit side with a one-cycle strobe and waits for that side to report the frame finished. It then follows the descriptor's link word. The chain ends at a descriptor whose link is zero or whose end-of-list flag is set. The head pointer is then left on that last transmitted descriptor.

Software adds work by patching the link word of the held descriptor in memory and kicking again. It does not rewrite the pointer. On such a restart the engine reads the held descriptor again and jumps to whatever its link now names. The pointer register only takes a write while it holds zero, which is the state after a queue reset. Any later write is dropped, so a careless rewrite cannot redirect a queue that has already run.

Each descriptor occupies two consecutive words. The word at the descriptor address is the link pointer. The word one word-size above it is the buffer address, and bit 0 of that word is the end-of-list flag. The strobe carries the buffer address with bit 0 forced to zero.

Top module: `txq_chain_dma`

## Requirements
- R1: After `rst_n` low, or in the cycle after `q_reset` is high, `hp_value` is zero, `running` is 0 and no read request is raised.
- R2: A pulse on `hp_wr` loads `hp_wdata` into the head pointer only when the pointer is zero and the queue is stopped. Otherwise the write is ignored and `hp_value` keeps its value.
- R3: A `kick` that follows an accepted nonzero head write starts reading at that head address. A `kick` while the pointer is zero does nothing: no request is made and `running` stays 0.
- R4: A descriptor at address A is read in two beats, first the link at A and then the buffer word at A + 4. Each request holds its valid and address until `rd_req_ready`, and the data returns with `rd_rsp_valid`.
- R5: Every descriptor handed on yields `frame_issue` for exactly one cycle, with `frame_buf` equal to the buffer word with bit 0 cleared.
- R6: After `frame_issue`, no read request is raised until `frame_done` has pulsed.
- R7: Walking stops after transmitting a descriptor whose link word is zero.
- R8: Walking also stops after transmitting a descriptor whose end-of-list bit (bit 0 of the buffer word) is 1, whatever its link holds.
- R9: On stopping, `hp_value` holds the address of the last descriptor transmitted, `running` falls, and `chain_done` pulses for one cycle.
- R10: A `kick` while stopped with a nonzero pointer, after any accepted first-descriptor transmit, re-reads the held descriptor first. If its link is nonzero and its end-of-list bit is 0, the engine jumps to the link and walks from there.
- R11: If the held descriptor re-read on a restart has a zero link or its end-of-list bit set, no frame is issued, `hp_value` is unchanged, and the queue stops again with a `chain_done` pulse.
- R12: A `kick` received while `running` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_reset | input | 1 | Synchronous queue reset; clears pointer and stops the queue |
| hp_wr | input | 1 | Head-pointer write strobe |
| hp_wdata | input | ADDR_W | Head-pointer write value |
| kick | input | 1 | Start or restart pulse |
| hp_value | output | ADDR_W | Current head-pointer register |
| running | output | 1 | 1 while the queue is active |
| chain_done | output | 1 | One-cycle pulse when the queue stops |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request accepted |
| rd_req_addr | output | ADDR_W | Memory read byte address |
| rd_rsp_valid | input | 1 | Memory read data valid |
| rd_rsp_data | input | ADDR_W | Memory read data word |
| frame_issue | output | 1 | One-cycle strobe handing a buffer to the transmit side |
| frame_buf | output | ADDR_W | Buffer address, bit 0 cleared |
| frame_done | input | 1 | Transmit side finished the issued frame |

## Verification
The bound checker watches these properties on every cycle:
- the read request holds steady until it is accepted;
- no read goes out between a frame strobe and its done pulse;
- the strobe lasts one cycle and its buffer has bit 0 clear;
- a queue reset clears the pointer and stops the queue;
- a pointer write against a nonzero stopped pointer changes nothing.

The bench scenarios cover what needs memory contents and a sequence of kicks:
- where a chain stops, for a null link and for the end-of-list bit;
- that the pointer is left on the last transmitted descriptor;
- that a restart re-reads the held descriptor and follows its patched link;
- that a restart on a dead link issues nothing;
- that a second kick during a walk changes nothing.

// File: rtl/txq_pkg.sv
// txq_pkg: shared state encodings and descriptor field positions for the
// linked-descriptor transmit queue. Assumes one word equals ADDR_W bits.
package txq_pkg;

    // Queue-level control states.
    typedef enum logic [2:0] {
        Q_IDLE,
        Q_FETCH,
        Q_REFETCH,
        Q_ISSUE,
        Q_WAIT_DONE
    } q_state_t;

    // Two-beat descriptor reader states.
    typedef enum logic [1:0] {
        F_IDLE,
        F_REQ,
        F_RSP
    } f_state_t;

    // End-of-list flag position inside the buffer word.
    localparam int EOL_BIT = 0;

endpackage

// File: rtl/txq_desc_fetch.sv
// txq_desc_fetch: reads one two-word descriptor (link word, then buffer
// word one word above it) over a request/response port with one request
// outstanding at a time. Assumes start is only pulsed while idle and
// responses return in order. Abort drops any fetch in flight.
module txq_desc_fetch
    import txq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_data,
    output logic              fetched,
    output logic [ADDR_W-1:0] link,
    output logic [ADDR_W-1:0] bufw
);

    localparam int WORD_BYTES = ADDR_W / 8;
    localparam logic [ADDR_W-1:0] BEAT1_OFS = ADDR_W'(WORD_BYTES);

    f_state_t          f_q;
    logic              beat_q;
    logic [ADDR_W-1:0] base_q;

    // Sequence request and response beats, capture the two descriptor words.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            f_q     <= F_IDLE;
            beat_q  <= 1'b0;
            base_q  <= '0;
            fetched <= 1'b0;
            link    <= '0;
            bufw    <= '0;
        end else begin
            fetched <= 1'b0;
            case (f_q)
                F_IDLE: begin
                    if (start) begin
                        base_q <= base;
                        beat_q <= 1'b0;
                        f_q    <= F_REQ;
                    end
                end
                F_REQ: begin
                    if (req_ready) f_q <= F_RSP;
                end
                F_RSP: begin
                    if (rsp_valid) begin
                        if (!beat_q) begin
                            link   <= rsp_data;
                            beat_q <= 1'b1;
                            f_q    <= F_REQ;
                        end else begin
                            bufw    <= rsp_data;
                            fetched <= 1'b1;
                            f_q     <= F_IDLE;
                        end
                    end
                end
                default: f_q <= F_IDLE;
            endcase
        end
    end

    // Present the request for the current beat.
    always_comb begin
        req_valid = (f_q == F_REQ);
        req_addr  = beat_q ? (base_q + BEAT1_OFS) : base_q;
    end

endmodule

// File: rtl/txq_head_ptr.sv
// txq_head_ptr: head-pointer register. A software write lands only while
// the register is zero and the queue is stopped. The pointer otherwise
// moves only by following a link. The fresh flag marks a written head whose
// first descriptor has not yet been issued.
module txq_head_ptr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_reset,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              stopped,
    input  logic              follow,
    input  logic [ADDR_W-1:0] follow_addr,
    input  logic              issued,
    output logic [ADDR_W-1:0] ptr,
    output logic              fresh
);

    logic accept;

    // Decide whether a software write is honoured.
    always_comb accept = wr_en && stopped && (ptr == '0);

    // Update pointer and fresh flag.
    always_ff @(posedge clk) begin
        if (!rst_n || q_reset) begin
            ptr   <= '0;
            fresh <= 1'b0;
        end else if (accept) begin
            ptr   <= wr_data;
            fresh <= (wr_data != '0);
        end else begin
            if (follow) ptr   <= follow_addr;
            if (issued) fresh <= 1'b0;
        end
    end

endmodule

// File: rtl/txq_chain_dma.sv
// txq_chain_dma: one transmit queue walking a linked descriptor chain.
// A kick after a fresh head write starts at the head. A kick later on
// re-reads the held (last transmitted) descriptor and follows its link.
// Assumes the transmit side answers each frame_issue with one frame_done.
module txq_chain_dma
    import txq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_reset,
    input  logic              hp_wr,
    input  logic [ADDR_W-1:0] hp_wdata,
    input  logic              kick,
    output logic [ADDR_W-1:0] hp_value,
    output logic              running,
    output logic              chain_done,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [ADDR_W-1:0] rd_rsp_data,
    output logic              frame_issue,
    output logic [ADDR_W-1:0] frame_buf,
    input  logic              frame_done
);

    localparam logic [ADDR_W-1:0] EOL_MASK = ADDR_W'(1) << EOL_BIT;

    q_state_t          st_q;
    logic              done_q;
    logic              fetch_start;
    logic [ADDR_W-1:0] fetch_base;
    logic              fetched;
    logic [ADDR_W-1:0] d_link;
    logic [ADDR_W-1:0] d_buf;
    logic              follow;
    logic              issued;
    logic              fresh;
    logic              chain_end;

    txq_head_ptr #(.ADDR_W(ADDR_W)) ptr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .q_reset     (q_reset),
        .wr_en       (hp_wr),
        .wr_data     (hp_wdata),
        .stopped     (st_q == Q_IDLE),
        .follow      (follow),
        .follow_addr (d_link),
        .issued      (issued),
        .ptr         (hp_value),
        .fresh       (fresh)
    );

    txq_desc_fetch #(.ADDR_W(ADDR_W)) fetch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (q_reset),
        .start     (fetch_start),
        .base      (fetch_base),
        .req_valid (rd_req_valid),
        .req_ready (rd_req_ready),
        .req_addr  (rd_req_addr),
        .rsp_valid (rd_rsp_valid),
        .rsp_data  (rd_rsp_data),
        .fetched   (fetched),
        .link      (d_link),
        .bufw      (d_buf)
    );

    // A descriptor ends the chain on a null link or a set end-of-list bit.
    always_comb chain_end = (d_link == '0) || ((d_buf & EOL_MASK) != '0);

    // Fetch launches, pointer follow and issue marking per state.
    always_comb begin
        fetch_start = 1'b0;
        fetch_base  = hp_value;
        follow      = 1'b0;
        issued      = 1'b0;
        case (st_q)
            Q_IDLE: begin
                if (kick && (fresh || hp_value != '0)) fetch_start = 1'b1;
            end
            Q_ISSUE: issued = 1'b1;
            Q_WAIT_DONE: begin
                if (frame_done && !chain_end) begin
                    follow      = 1'b1;
                    fetch_start = 1'b1;
                    fetch_base  = d_link;
                end
            end
            Q_REFETCH: begin
                if (fetched && !chain_end) begin
                    follow      = 1'b1;
                    fetch_start = 1'b1;
                    fetch_base  = d_link;
                end
            end
            default: ;
        endcase
    end

    // Queue state sequencing and the stop pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || q_reset) begin
            st_q   <= Q_IDLE;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                Q_IDLE: begin
                    if (kick && fresh)                st_q <= Q_FETCH;
                    else if (kick && hp_value != '0)  st_q <= Q_REFETCH;
                end
                Q_FETCH: begin
                    if (fetched) st_q <= Q_ISSUE;
                end
                Q_ISSUE: st_q <= Q_WAIT_DONE;
                Q_WAIT_DONE: begin
                    if (frame_done) begin
                        if (chain_end) begin
                            st_q   <= Q_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            st_q <= Q_FETCH;
                        end
                    end
                end
                Q_REFETCH: begin
                    if (fetched) begin
                        if (chain_end) begin
                            st_q   <= Q_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            st_q <= Q_FETCH;
                        end
                    end
                end
                default: st_q <= Q_IDLE;
            endcase
        end
    end

    // Drive the status and transmit-side outputs.
    always_comb begin
        running     = (st_q != Q_IDLE);
        chain_done  = done_q;
        frame_issue = (st_q == Q_ISSUE);
        frame_buf   = d_buf & ~EOL_MASK;
    end

endmodule

// File: rtl/txq_chain_dma_chk.sv
// txq_chain_dma_chk: cycle-by-cycle property checker for txq_chain_dma,
// attached by bind. Tracks an outstanding-frame flag of its own.
module txq_chain_dma_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              q_reset,
    input logic              hp_wr,
    input logic              kick,
    input logic [ADDR_W-1:0] hp_value,
    input logic              running,
    input logic              chain_done,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_req_addr,
    input logic              frame_issue,
    input logic [ADDR_W-1:0] frame_buf,
    input logic              frame_done
);

    logic out_q;

    // Remember a frame handed on until its done pulse or a queue reset.
    always_ff @(posedge clk) begin
        if (!rst_n || q_reset)  out_q <= 1'b0;
        else if (frame_issue)   out_q <= 1'b1;
        else if (frame_done)    out_q <= 1'b0;
    end

    // R1
    qreset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_reset |=> (hp_value == '0) && !running && !rd_req_valid);

    // R2
    write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_wr && hp_value != '0 && !running && !kick && !q_reset)
        |=> hp_value == $past(hp_value));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready && !q_reset)
        |=> rd_req_valid && $stable(rd_req_addr));

    // R5
    issue_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_issue |=> !frame_issue);

    // R5
    issue_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_issue |-> running && ((frame_buf & ADDR_W'(1)) == '0));

    // R6
    done_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_q && rd_req_valid));

    // R9
    stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |-> !running);

endmodule

bind txq_chain_dma txq_chain_dma_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .q_reset      (q_reset),
    .hp_wr        (hp_wr),
    .kick         (kick),
    .hp_value     (hp_value),
    .running      (running),
    .chain_done   (chain_done),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .frame_issue  (frame_issue),
    .frame_buf    (frame_buf),
    .frame_done   (frame_done)
);

// File: tb/txq_chain_dma_tb_top.sv
`timescale 1ns/1ps
module txq_chain_dma_tb_top;

    localparam int ADDR_W   = 32;
    localparam int DONE_LAT = 3;
    localparam int NVEC     = 3;

    // Chain walk vectors: head, frames issued, first buffer, last buffer, final pointer.
    localparam logic [31:0] V_HEAD  [NVEC] = '{32'h10, 32'h40, 32'h60};
    localparam int          V_CNT   [NVEC] = '{3, 1, 1};
    localparam logic [31:0] V_FIRST [NVEC] = '{32'h100, 32'h400, 32'h600};
    localparam logic [31:0] V_LAST  [NVEC] = '{32'h300, 32'h400, 32'h600};
    localparam logic [31:0] V_FINAL [NVEC] = '{32'h30, 32'h40, 32'h60};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              q_reset = 1'b0;
    logic              hp_wr = 1'b0;
    logic [ADDR_W-1:0] hp_wdata = '0;
    logic              kick = 1'b0;
    logic [ADDR_W-1:0] hp_value;
    logic              running;
    logic              chain_done;
    logic              rd_req_valid;
    logic              rd_req_ready = 1'b0;
    logic [ADDR_W-1:0] rd_req_addr;
    logic              rd_rsp_valid = 1'b0;
    logic [ADDR_W-1:0] rd_rsp_data = '0;
    logic              frame_issue;
    logic [ADDR_W-1:0] frame_buf;
    logic              frame_done = 1'b0;

    logic [31:0] mem [0:63];
    logic [31:0] issued_buf [0:15];
    int          n_issued = 0;
    int          n_done = 0;
    int          gate_viol = 0;
    int          multi_viol = 0;
    int          cyc = 0;
    int          done_cnt = 0;
    logic        outstanding = 1'b0;
    logic        prev_issue = 1'b0;
    logic        pend = 1'b0;
    logic [31:0] pend_d = '0;
    logic        first_seen = 1'b0;
    logic [31:0] first_addr = '0;
    int          total = 0;
    int          bad = 0;
    logic        finished = 1'b0;

    always #2 clk = ~clk;

    txq_chain_dma #(.ADDR_W(ADDR_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .q_reset      (q_reset),
        .hp_wr        (hp_wr),
        .hp_wdata     (hp_wdata),
        .kick         (kick),
        .hp_value     (hp_value),
        .running      (running),
        .chain_done   (chain_done),
        .rd_req_valid (rd_req_valid),
        .rd_req_ready (rd_req_ready),
        .rd_req_addr  (rd_req_addr),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_data  (rd_rsp_data),
        .frame_issue  (frame_issue),
        .frame_buf    (frame_buf),
        .frame_done   (frame_done)
    );

    // Memory model, transmit-side responder and monitors, all at the falling edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        rd_rsp_valid = pend;
        rd_rsp_data  = pend_d;
        pend = 1'b0;
        if (q_reset) outstanding = 1'b0;
        if (frame_issue && prev_issue) multi_viol = multi_viol + 1;
        prev_issue = frame_issue;
        if (frame_issue) begin
            if (n_issued < 16) issued_buf[n_issued] = frame_buf;
            n_issued    = n_issued + 1;
            outstanding = 1'b1;
            done_cnt    = DONE_LAT;
        end
        if (chain_done) n_done = n_done + 1;
        if (rd_req_valid && outstanding) gate_viol = gate_viol + 1;
        if (rd_req_valid && !first_seen) begin
            first_seen = 1'b1;
            first_addr = rd_req_addr;
        end
        frame_done = 1'b0;
        if (outstanding) begin
            if (done_cnt == 0) begin
                frame_done  = 1'b1;
                outstanding = 1'b0;
            end else begin
                done_cnt = done_cnt - 1;
            end
        end
        rd_req_ready = (cyc % 3) != 0;
        if (rd_req_valid && rd_req_ready) begin
            pend   = 1'b1;
            pend_d = mem[rd_req_addr[7:2]];
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_qreset();
        tick(1);
        q_reset = 1'b1;
        tick(2);
        q_reset = 1'b0;
        tick(1);
    endtask

    task automatic write_head(input logic [31:0] a);
        tick(1);
        hp_wr = 1'b1;
        hp_wdata = a;
        tick(1);
        hp_wr = 1'b0;
        tick(1);
    endtask

    task automatic kick_pulse(input logic clear);
        tick(1);
        if (clear) begin
            n_issued   = 0;
            first_seen = 1'b0;
            gate_viol  = 0;
        end
        kick = 1'b1;
        tick(1);
        kick = 1'b0;
    endtask

    task automatic run_wait(input int base_done);
        int k;
        for (k = 0; k < 3000 && n_done == base_done; k++) tick(1);
        total = total + 1;
        if (n_done == base_done) begin
            bad = bad + 1;
            $display("FAIL R9 stop pulse actual=%0d expected=%0d", n_done, base_done + 1);
        end
        tick(3);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int b;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        // 0x10 -> 0x20 -> 0x30 (null link)
        mem[4]  = 32'h20;  mem[5]  = 32'h100;
        mem[8]  = 32'h30;  mem[9]  = 32'h200;
        mem[12] = 32'h0;   mem[13] = 32'h300;
        // 0x40 has end-of-list set but a nonzero link
        mem[16] = 32'h50;  mem[17] = 32'h401;
        mem[20] = 32'h0;   mem[21] = 32'h500;
        // 0x60 single, 0x70 used as an appended frame
        mem[24] = 32'h0;   mem[25] = 32'h600;
        mem[28] = 32'h0;   mem[29] = 32'h700;

        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        check_eq("R1 pointer after reset", hp_value, 32'h0);
        check_eq("R1 running after reset", {31'b0, running}, 32'h0);
        check_eq("R1 no request after reset", {31'b0, rd_req_valid}, 32'h0);

        // R3 kick with zero pointer does nothing
        kick_pulse(1'b1);
        tick(12);
        check_eq("R3 zero-pointer kick running", {31'b0, running}, 32'h0);
        check_eq("R3 zero-pointer kick requests", {31'b0, first_seen}, 32'h0);

        // Vector table of chain walks
        for (int i = 0; i < NVEC; i++) begin
            do_qreset();
            write_head(V_HEAD[i]);
            check_eq("R2 head write from zero", hp_value, V_HEAD[i]);
            b = n_done;
            kick_pulse(1'b1);
            run_wait(b);
            check_eq("R3 R4 first request at head", first_addr, V_HEAD[i]);
            check_eq(i == 1 ? "R8 frames before end-of-list stop" : "R7 frames before null-link stop",
                     n_issued, V_CNT[i]);
            check_eq("R5 first buffer", issued_buf[0], V_FIRST[i]);
            check_eq("R5 last buffer", issued_buf[V_CNT[i] - 1], V_LAST[i]);
            check_eq("R9 pointer on last transmitted", hp_value, V_FINAL[i]);
            check_eq("R6 no read while frame pending", gate_viol, 0);
        end

        // R2 write ignored while pointer nonzero
        write_head(32'h10);
        check_eq("R2 write over nonzero ignored", hp_value, 32'h60);

        // R10 restart follows patched link of held descriptor
        mem[24] = 32'h70;
        b = n_done;
        kick_pulse(1'b1);
        run_wait(b);
        check_eq("R10 restart re-reads held descriptor", first_addr, 32'h60);
        check_eq("R10 restart frame count", n_issued, 1);
        check_eq("R10 restart buffer", issued_buf[0], 32'h700);
        check_eq("R10 pointer after restart", hp_value, 32'h70);

        // R11 restart on a null link issues nothing
        b = n_done;
        kick_pulse(1'b1);
        run_wait(b);
        check_eq("R11 null-link restart frames", n_issued, 0);
        check_eq("R11 null-link restart pointer", hp_value, 32'h70);
        check_eq("R11 null-link restart running", {31'b0, running}, 32'h0);

        // R11 restart on an end-of-list held descriptor issues nothing
        do_qreset();
        write_head(32'h40);
        b = n_done;
        kick_pulse(1'b1);
        run_wait(b);
        b = n_done;
        kick_pulse(1'b1);
        run_wait(b);
        check_eq("R11 end-of-list restart frames", n_issued, 0);
        check_eq("R11 end-of-list restart pointer", hp_value, 32'h40);

        // R12 kick during a walk is ignored
        do_qreset();
        check_eq("R1 pointer after queue reset", hp_value, 32'h0);
        write_head(32'h10);
        b = n_done;
        kick_pulse(1'b1);
        tick(6);
        check_eq("R12 running mid-walk", {31'b0, running}, 32'h1);
        kick_pulse(1'b0);
        run_wait(b);
        check_eq("R12 frames with extra kick", n_issued, 3);
        check_eq("R12 pointer with extra kick", hp_value, 32'h30);
        check_eq("R12 single stop pulse", n_done, b + 1);

        // R1 queue reset in the middle of a walk
        do_qreset();
        write_head(32'h10);
        kick_pulse(1'b1);
        tick(5);
        do_qreset();
        check_eq("R1 pointer after mid-walk reset", hp_value, 32'h0);
        check_eq("R1 running after mid-walk reset", {31'b0, running}, 32'h0);
        tick(20);
        write_head(32'h60);
        check_eq("R2 write accepted after queue reset", hp_value, 32'h60);

        check_eq("R5 strobe width", multi_viol, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule